// File: doc/BRIEF.md
# Masked SIMD Array Controller

This block is a small single-instruction, multiple-data array engine. One control unit walks an external instruction memory and broadcasts each decoded instruction to eight processing elements. Every element has a 16-bit signed accumulator and a private 16-word data memory. The control unit owns eight 8-bit index registers, a program counter and an 8-bit enable mask. Bit k of the mask enables element k. Bit k of an index register doubles as element k's condition flag.

Vector instructions act on all enabled elements in the same cycle, each on its own memory word at a shared row address. A vector compare writes its per-element results as a bitmap into an index register. The bitmap can then be combined with other index registers, copied into the mask, or tested by branches that ask whether all, any or none of its bits are set. A host loads and reads the element memories through a side port while the engine is idle. A start pulse runs the program from address 0 until a halt instruction is reached. Every instruction takes exactly one clock.

Top module: `simd_array_ctrl`

## Requirements
- R1: After reset, pc_o is 0, busy_o and done_o are 0, mask_o is 8'hFF, and every accumulator in acc_o is 0. Element k's accumulator sits at acc_o[16k+15:16k].
- R2: The instruction word is 20 bits: opcode [19:15], register a [14:12], register b [11:9], index flag X [8], immediate [7:0]. The opcodes are NOP 0, HALT 1, LOAD 2, STO 3, ADD 4, SUB 5, MUL 6, BCAST 7, ENXC 8, ICNX 9, CPNX 10, CLSS 11, CEQL 12, BRALL 13, BRANY 14, BRNON 15, AND 16, OR 17, CMP 18, LDMSK 19, STMSK 20, and any other value acts as NOP. A start_i pulse while idle sets pc_o to 0 and busy_o to 1, and clears done_o. HALT clears busy_o, sets done_o and leaves pc_o on the HALT.
- R3: The row address is imm[3:0], plus the low four bits of register a when X is 1, taken modulo 16. In every enabled element, LOAD copies the row word into the accumulator and STO writes the accumulator to the row word. ADD, SUB and MUL combine the accumulator with the row word, and MUL keeps the low 16 bits of the product.
- R4: An element whose mask bit is 0 keeps its accumulator and its memory unchanged through LOAD, STO, ADD, SUB, MUL and BCAST.
- R5: BCAST copies the accumulator of element (register a mod 8) into every enabled accumulator.
- R6: ENXC sets register a to imm. ICNX adds imm to register a modulo 256. CPNX jumps to imm[5:0] when register a is less than register b, comparing both as unsigned numbers.
- R7: CLSS sets bit k of register a to 1 when accumulator k is less than element k's row word, comparing as signed numbers, and to 0 otherwise. CEQL does the same for equality. Both write all eight bits regardless of the mask.
- R8: BRALL, BRANY and BRNON jump to imm[5:0] when register a is 8'hFF, is nonzero, or is zero, respectively.
- R9: AND and OR set register a to register a AND, or OR, register b. CMP inverts register a. LDMSK copies register a into the mask. STMSK copies the mask into register a.
- R10: A host write (dm_we_i) stores dm_wdata_i in word dm_addr_i of element dm_pe_i only while busy_o is 0. While busy_o is 1 the write has no effect. dm_rdata_o shows that word combinationally.
- R11: Every instruction other than HALT and a taken branch advances pc_o by 1 modulo 64 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin execution at address 0 (honoured while idle) |
| instr_i | input | 20 | Instruction word fetched from address pc_o |
| dm_we_i | input | 1 | Host write strobe for element memory |
| dm_pe_i | input | 3 | Host element select |
| dm_addr_i | input | 4 | Host word address |
| dm_wdata_i | input | 16 | Host write data |
| pc_o | output | 6 | Program counter, the fetch address |
| busy_o | output | 1 | Program is running |
| done_o | output | 1 | HALT was executed |
| mask_o | output | 8 | Current enable mask |
| acc_o | output | 128 | All accumulators, element k at bits [16k+15:16k] |
| dm_rdata_o | output | 16 | Host read data |

## Verification
The instruction at pc_o is decoded in the same cycle it is presented. Its effect on pc_o, mask_o, done_o, busy_o and acc_o therefore appears after exactly one rising edge. A start pulse or an idle host write is likewise visible one edge later, and dm_rdata_o follows its address with no delay. The bench drives inputs and steps its behavioural model at the falling edge. After the following rising edge it compares every one of these outputs at the next falling edge, so a result is always checked in the cycle it is due. Memory contents are read back through the host port after each halt.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int PE_COUNT   = 8;
    localparam int IDX_COUNT  = 8;
    localparam int ACC_BITS   = 16;
    localparam int MEM_WORDS  = 16;
    localparam int ROW_BITS   = $clog2(MEM_WORDS);
    localparam int PC_BITS    = 6;
    localparam int OP_BITS    = 5;
    localparam int INSTR_BITS = OP_BITS + 2 * $clog2(IDX_COUNT) + 1 + PE_COUNT;

    typedef enum logic [OP_BITS-1:0] {
        OP_NOP   = 5'd0,
        OP_HALT  = 5'd1,
        OP_LOAD  = 5'd2,
        OP_STO   = 5'd3,
        OP_ADD   = 5'd4,
        OP_SUB   = 5'd5,
        OP_MUL   = 5'd6,
        OP_BCAST = 5'd7,
        OP_ENXC  = 5'd8,
        OP_ICNX  = 5'd9,
        OP_CPNX  = 5'd10,
        OP_CLSS  = 5'd11,
        OP_CEQL  = 5'd12,
        OP_BRALL = 5'd13,
        OP_BRANY = 5'd14,
        OP_BRNON = 5'd15,
        OP_AND   = 5'd16,
        OP_OR    = 5'd17,
        OP_CMP   = 5'd18,
        OP_LDMSK = 5'd19,
        OP_STMSK = 5'd20
    } opcode_e;

    typedef enum logic [2:0] {
        LANE_NONE,
        LANE_LOAD,
        LANE_STORE,
        LANE_ADD,
        LANE_SUB,
        LANE_MUL,
        LANE_BCAST
    } lane_op_e;

endpackage

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter int ACC_W  = ACC_BITS,
    parameter int DEPTH  = MEM_WORDS,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  lane_op_e         op_i,
    input  logic [AW-1:0]    row_i,
    input  logic [ACC_W-1:0] bcast_i,
    input  logic             host_we_i,
    input  logic [AW-1:0]    host_addr_i,
    input  logic [ACC_W-1:0] host_wdata_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             lt_o,
    output logic             eq_o,
    output logic [ACC_W-1:0] host_rdata_o
);

    typedef struct packed {
        logic [ACC_W-1:0]            acc;
        logic [DEPTH-1:0][ACC_W-1:0] mem;
    } lane_state_t;

    lane_state_t      s_d, s_q;
    logic [ACC_W-1:0] operand;
    logic [ACC_W-1:0] product;

    always_comb begin
        s_d     = s_q;
        operand = s_q.mem[row_i];
        product = s_q.acc * operand;
        if (en_i) begin
            case (op_i)
                LANE_LOAD:  s_d.acc = operand;
                LANE_STORE: s_d.mem[row_i] = s_q.acc;
                LANE_ADD:   s_d.acc = s_q.acc + operand;
                LANE_SUB:   s_d.acc = s_q.acc - operand;
                LANE_MUL:   s_d.acc = product;
                LANE_BCAST: s_d.acc = bcast_i;
                default:    ;
            endcase
        end
        if (host_we_i) begin
            s_d.mem[host_addr_i] = host_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_o        = s_q.acc;
    assign lt_o         = $signed(s_q.acc) < $signed(operand);
    assign eq_o         = (s_q.acc == operand);
    assign host_rdata_o = s_q.mem[host_addr_i];

    // R4: a disabled lane keeps its accumulator
    a_r4_masked_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_o));

    // R4, R10: memory moves only by an enabled store or an accepted host write
    a_r4_masked_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !host_we_i) |=> $stable(s_q.mem));

    // R3: an enabled load delivers the addressed word
    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == LANE_LOAD && !host_we_i) |=> acc_o == $past(operand));

endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
    import simd_pkg::*;
#(
    parameter int NUM_PE  = PE_COUNT,
    parameter int NUM_IDX = IDX_COUNT,
    parameter int PC_W    = PC_BITS,
    parameter int ROW_W   = ROW_BITS,
    parameter int INSTR_W = INSTR_BITS,
    parameter int SEL_W   = $clog2(NUM_PE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [NUM_PE-1:0]  lt_i,
    input  logic [NUM_PE-1:0]  eq_i,
    output logic [PC_W-1:0]    pc_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [NUM_PE-1:0]  mask_o,
    output lane_op_e           lane_op_o,
    output logic [NUM_PE-1:0]  lane_en_o,
    output logic [ROW_W-1:0]   row_o,
    output logic [SEL_W-1:0]   bsel_o
);

    localparam int RW    = $clog2(NUM_IDX);
    localparam int OP_LO = INSTR_W - OP_BITS;
    localparam int RA_LO = OP_LO - RW;
    localparam int RB_LO = RA_LO - RW;
    localparam int X_BIT = RB_LO - 1;
    localparam int IMM_W = X_BIT;

    typedef struct packed {
        logic [PC_W-1:0]                 pc;
        logic                            run;
        logic                            done;
        logic [NUM_PE-1:0]               mask;
        logic [NUM_IDX-1:0][NUM_PE-1:0]  idx;
    } ctrl_state_t;

    ctrl_state_t       s_d, s_q;
    opcode_e           op;
    logic [RW-1:0]     ra, rb;
    logic              xb;
    logic [IMM_W-1:0]  imm;
    logic [NUM_PE-1:0] ra_val, rb_val;
    logic [PC_W-1:0]   target;
    logic [PC_W-1:0]   pc_inc;
    lane_op_e          vec_op;

    always_comb begin
        op     = opcode_e'(instr_i[INSTR_W-1:OP_LO]);
        ra     = instr_i[OP_LO-1:RA_LO];
        rb     = instr_i[RA_LO-1:RB_LO];
        xb     = instr_i[X_BIT];
        imm    = instr_i[IMM_W-1:0];
        ra_val = s_q.idx[ra];
        rb_val = s_q.idx[rb];
        target = imm[PC_W-1:0];
        pc_inc = s_q.pc + PC_W'(1);
        row_o  = imm[ROW_W-1:0] + (xb ? ra_val[ROW_W-1:0] : '0);
        bsel_o = ra_val[SEL_W-1:0];
        vec_op = LANE_NONE;
        s_d    = s_q;

        if (!s_q.run) begin
            if (start_i) begin
                s_d.pc   = '0;
                s_d.run  = 1'b1;
                s_d.done = 1'b0;
            end
        end else begin
            s_d.pc = pc_inc;
            case (op)
                OP_HALT: begin
                    s_d.pc   = s_q.pc;
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end
                OP_LOAD:  vec_op = LANE_LOAD;
                OP_STO:   vec_op = LANE_STORE;
                OP_ADD:   vec_op = LANE_ADD;
                OP_SUB:   vec_op = LANE_SUB;
                OP_MUL:   vec_op = LANE_MUL;
                OP_BCAST: vec_op = LANE_BCAST;
                OP_ENXC:  s_d.idx[ra] = NUM_PE'(imm);
                OP_ICNX:  s_d.idx[ra] = ra_val + NUM_PE'(imm);
                OP_CPNX:  if (ra_val < rb_val) s_d.pc = target;
                OP_CLSS:  s_d.idx[ra] = lt_i;
                OP_CEQL:  s_d.idx[ra] = eq_i;
                OP_BRALL: if (&ra_val) s_d.pc = target;
                OP_BRANY: if (|ra_val) s_d.pc = target;
                OP_BRNON: if (ra_val == '0) s_d.pc = target;
                OP_AND:   s_d.idx[ra] = ra_val & rb_val;
                OP_OR:    s_d.idx[ra] = ra_val | rb_val;
                OP_CMP:   s_d.idx[ra] = ~ra_val;
                OP_LDMSK: s_d.mask = ra_val;
                OP_STMSK: s_d.idx[ra] = s_q.mask;
                default:  ;
            endcase
        end

        lane_op_o = vec_op;
        lane_en_o = (vec_op != LANE_NONE) ? s_q.mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o   = s_q.pc;
    assign busy_o = s_q.run;
    assign done_o = s_q.done;
    assign mask_o = s_q.mask;

    // R2: HALT freezes the fetch address and flags completion
    a_r2_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op == OP_HALT) |=> (done_o && !busy_o && pc_o == $past(pc_o)));

    // R2: a start while idle launches at address 0
    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pc_o == '0 && !done_o));

    // R11: straight-line instructions step the program counter
    a_r11_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(op inside {OP_HALT, OP_CPNX, OP_BRALL, OP_BRANY, OP_BRNON}))
        |=> pc_o == $past(pc_o) + PC_W'(1));

    // R8: a zero register makes the none-branch land on its target
    a_r8_none_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op == OP_BRNON && ra_val == '0) |=> pc_o == $past(target));

    // R9: the mask follows the register named by LDMSK
    a_r9_ldmsk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op == OP_LDMSK) |=> mask_o == $past(ra_val));

    // R2: an idle engine holds its fetch address
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(pc_o));

endmodule

// File: rtl/simd_array_ctrl.sv
module simd_array_ctrl
    import simd_pkg::*;
#(
    parameter int NUM_PE  = PE_COUNT,
    parameter int NUM_IDX = IDX_COUNT,
    parameter int ACC_W   = ACC_BITS,
    parameter int DEPTH   = MEM_WORDS,
    parameter int PC_W    = PC_BITS,
    parameter int INSTR_W = INSTR_BITS,
    parameter int AW      = $clog2(DEPTH),
    parameter int SEL_W   = $clog2(NUM_PE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [INSTR_W-1:0]      instr_i,
    input  logic                    dm_we_i,
    input  logic [SEL_W-1:0]        dm_pe_i,
    input  logic [AW-1:0]           dm_addr_i,
    input  logic [ACC_W-1:0]        dm_wdata_i,
    output logic [PC_W-1:0]         pc_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [NUM_PE-1:0]       mask_o,
    output logic [NUM_PE*ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0]        dm_rdata_o
);

    lane_op_e                       lane_op;
    logic [NUM_PE-1:0]              lane_en;
    logic [AW-1:0]                  row;
    logic [SEL_W-1:0]               bsel;
    logic [NUM_PE-1:0]              lt_vec, eq_vec;
    logic [NUM_PE-1:0][ACC_W-1:0]   acc_w;
    logic [NUM_PE-1:0][ACC_W-1:0]   rdata_w;

    simd_ctrl #(
        .NUM_PE  (NUM_PE),
        .NUM_IDX (NUM_IDX),
        .PC_W    (PC_W),
        .ROW_W   (AW),
        .INSTR_W (INSTR_W),
        .SEL_W   (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .instr_i   (instr_i),
        .lt_i      (lt_vec),
        .eq_i      (eq_vec),
        .pc_o      (pc_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .mask_o    (mask_o),
        .lane_op_o (lane_op),
        .lane_en_o (lane_en),
        .row_o     (row),
        .bsel_o    (bsel)
    );

    for (genvar k = 0; k < NUM_PE; k++) begin : g_lane
        logic host_we;
        assign host_we = dm_we_i && !busy_o && (dm_pe_i == SEL_W'(k));

        simd_pe #(
            .ACC_W (ACC_W),
            .DEPTH (DEPTH),
            .AW    (AW)
        ) u_pe (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (lane_en[k]),
            .op_i         (lane_op),
            .row_i        (row),
            .bcast_i      (acc_w[bsel]),
            .host_we_i    (host_we),
            .host_addr_i  (dm_addr_i),
            .host_wdata_i (dm_wdata_i),
            .acc_o        (acc_w[k]),
            .lt_o         (lt_vec[k]),
            .eq_o         (eq_vec[k]),
            .host_rdata_o (rdata_w[k])
        );
    end

    assign acc_o      = acc_w;
    assign dm_rdata_o = rdata_w[dm_pe_i];

    // R5: after a broadcast every enabled lane holds the selected source
    a_r5_bcast_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_op == LANE_BCAST && lane_en == '1) |=> $countones(acc_w[0] ^ acc_w[NUM_PE-1]) == 0);

endmodule

// File: tb/sim_simd_array_ctrl.sv
`timescale 1ns/1ps
module sim_simd_array_ctrl;
    import simd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] instr_i;
    logic        dm_we_i = 1'b0;
    logic [2:0]  dm_pe_i = '0;
    logic [3:0]  dm_addr_i = '0;
    logic [15:0] dm_wdata_i = '0;
    logic [5:0]  pc_o;
    logic        busy_o, done_o;
    logic [7:0]  mask_o;
    logic [127:0] acc_o;
    logic [15:0] dm_rdata_o;

    always #2 clk = ~clk;

    logic [19:0] imem [64];
    assign instr_i = imem[pc_o];

    simd_array_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .dm_we_i(dm_we_i), .dm_pe_i(dm_pe_i), .dm_addr_i(dm_addr_i),
        .dm_wdata_i(dm_wdata_i), .pc_o(pc_o), .busy_o(busy_o),
        .done_o(done_o), .mask_o(mask_o), .acc_o(acc_o), .dm_rdata_o(dm_rdata_o)
    );

    // behavioural reference state
    logic [15:0] m_acc [8];
    logic [15:0] m_mem [8][16];
    logic [7:0]  m_idx [8];
    logic [7:0]  m_mask;
    int          m_pc;
    bit          m_run, m_done;
    string       m_tag;
    int          n_vec = 0;
    int          n_bad = 0;

    task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [19:0] enc(int op, int ra, int rb, int x, int imm);
        return {5'(op), 3'(ra), 3'(rb), 1'(x), 8'(imm)};
    endfunction

    task automatic model_step(bit st, bit we, int pe, int a, logic [15:0] d);
        logic [19:0] w;
        int op, ra, rb, imm, row, npc;
        logic [7:0] va, vb, bits;
        logic [15:0] src;
        if (!m_run) begin
            m_tag = "R10";
            if (we) m_mem[pe][a] = d;
            if (st) begin m_pc = 0; m_run = 1; m_done = 0; m_tag = "R2"; end
            return;
        end
        w = imem[m_pc];
        op = int'(w[19:15]); ra = int'(w[14:12]); rb = int'(w[11:9]); imm = int'(w[7:0]);
        va = m_idx[ra]; vb = m_idx[rb];
        row = (imm + (w[8] ? int'(va) : 0)) % 16;
        npc = (m_pc + 1) % 64;
        src = m_acc[va % 8];
        bits = '0;
        m_tag = "R11";
        case (op)
            1: begin npc = m_pc; m_run = 0; m_done = 1; m_tag = "R2"; end
            2, 3, 4, 5, 6, 7: begin
                m_tag = (op == 7) ? "R5" : "R3";
                if (m_mask != 8'hFF) m_tag = "R4";
                for (int k = 0; k < 8; k++) if (m_mask[k]) begin
                    case (op)
                        2: m_acc[k] = m_mem[k][row];
                        3: m_mem[k][row] = m_acc[k];
                        4: m_acc[k] = m_acc[k] + m_mem[k][row];
                        5: m_acc[k] = m_acc[k] - m_mem[k][row];
                        6: m_acc[k] = m_acc[k] * m_mem[k][row];
                        default: m_acc[k] = src;
                    endcase
                end
            end
            8:  begin m_idx[ra] = 8'(imm); m_tag = "R6"; end
            9:  begin m_idx[ra] = va + 8'(imm); m_tag = "R6"; end
            10: begin if (va < vb) npc = imm % 64; m_tag = "R6"; end
            11, 12: begin
                for (int k = 0; k < 8; k++)
                    bits[k] = (op == 11) ? ($signed(m_acc[k]) < $signed(m_mem[k][row]))
                                         : (m_acc[k] == m_mem[k][row]);
                m_idx[ra] = bits; m_tag = "R7";
            end
            13: begin if (va == 8'hFF) npc = imm % 64; m_tag = "R8"; end
            14: begin if (va != 0) npc = imm % 64; m_tag = "R8"; end
            15: begin if (va == 0) npc = imm % 64; m_tag = "R8"; end
            16: begin m_idx[ra] = va & vb; m_tag = "R9"; end
            17: begin m_idx[ra] = va | vb; m_tag = "R9"; end
            18: begin m_idx[ra] = ~va; m_tag = "R9"; end
            19: begin m_mask = va; m_tag = "R9"; end
            20: begin m_idx[ra] = m_mask; m_tag = "R9"; end
            default: ;
        endcase
        m_pc = npc;
    endtask

    task automatic compare_all();
        logic [127:0] exp;
        for (int k = 0; k < 8; k++) exp[16*k +: 16] = m_acc[k];
        chk(m_tag, "pc", 128'(pc_o), 128'(m_pc));
        chk(m_tag, "mask", 128'(mask_o), 128'(m_mask));
        chk(m_tag, "busy/done", 128'({busy_o, done_o}), 128'({m_run, m_done}));
        chk(m_tag, "acc", acc_o, exp);
    endtask

    task automatic tick(bit st, bit we, int pe, int a, logic [15:0] d);
        start_i = st; dm_we_i = we; dm_pe_i = 3'(pe); dm_addr_i = 4'(a); dm_wdata_i = d;
        model_step(st, we, pe, a, d);
        @(posedge clk);
        @(negedge clk);
        start_i = 0; dm_we_i = 0;
        compare_all();
    endtask

    task automatic run_prog(bit poke);
        int guard;
        tick(1, 0, 0, 0, '0);
        guard = 0;
        while (m_run && guard < 400) begin
            // R10: host writes attempted while busy must be dropped
            tick(0, poke, 0, 15, 16'hBEEF);
            guard++;
        end
        repeat (3) tick(0, 0, 0, 0, '0);
        chk("R2", "done after halt", 128'(done_o), 128'(1));
    endtask

    task automatic readback(string req);
        for (int p = 0; p < 8; p++)
            for (int a = 0; a < 16; a++) begin
                dm_pe_i = 3'(p); dm_addr_i = 4'(a);
                #0.5;
                chk(req, "memory word", 128'(dm_rdata_o), 128'(m_mem[p][a]));
            end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = '0;
        for (int k = 0; k < 8; k++) begin
            m_acc[k] = '0; m_idx[k] = '0;
            for (int a = 0; a < 16; a++) m_mem[k][a] = '0;
        end
        m_mask = 8'hFF; m_pc = 0; m_run = 0; m_done = 0; m_tag = "R1";

        // program: arithmetic, compares, branches, masking, broadcast, indexed loop
        imem[0]  = enc(8, 1, 0, 0, 0);
        imem[1]  = enc(2, 0, 0, 0, 0);
        imem[2]  = enc(4, 0, 0, 0, 1);
        imem[3]  = enc(6, 0, 0, 0, 3);
        imem[4]  = enc(5, 0, 0, 0, 2);
        imem[5]  = enc(3, 0, 0, 0, 4);
        imem[6]  = enc(11, 2, 0, 0, 1);
        imem[7]  = enc(12, 3, 0, 0, 4);
        imem[8]  = enc(13, 3, 0, 0, 10);
        imem[9]  = enc(1, 0, 0, 0, 0);
        imem[10] = enc(8, 4, 0, 0, 8'hA5);
        imem[11] = enc(19, 4, 0, 0, 0);
        imem[12] = enc(2, 0, 0, 0, 2);
        imem[13] = enc(8, 5, 0, 0, 3);
        imem[14] = enc(7, 5, 0, 0, 0);
        imem[15] = enc(3, 0, 0, 0, 5);
        imem[16] = enc(20, 6, 0, 0, 0);
        imem[17] = enc(18, 6, 0, 0, 0);
        imem[18] = enc(16, 6, 4, 0, 0);
        imem[19] = enc(15, 6, 0, 0, 21);
        imem[20] = enc(1, 0, 0, 0, 0);
        imem[21] = enc(17, 6, 2, 0, 0);
        imem[22] = enc(14, 6, 0, 0, 24);
        imem[23] = enc(0, 0, 0, 0, 0);
        imem[24] = enc(8, 7, 0, 0, 8'hFF);
        imem[25] = enc(19, 7, 0, 0, 0);
        imem[26] = enc(8, 1, 0, 0, 0);
        imem[27] = enc(8, 0, 0, 0, 4);
        imem[28] = enc(2, 1, 0, 1, 0);
        imem[29] = enc(6, 0, 0, 0, 1);
        imem[30] = enc(3, 1, 0, 1, 8);
        imem[31] = enc(9, 1, 0, 0, 1);
        imem[32] = enc(10, 1, 0, 0, 28);
        imem[33] = enc(12, 2, 0, 0, 9);
        imem[34] = enc(13, 2, 0, 0, 36);
        imem[35] = enc(0, 0, 0, 0, 0);
        imem[36] = enc(1, 0, 0, 0, 0);

        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pc", 128'(pc_o), 128'(0));
        chk("R1", "mask", 128'(mask_o), 128'(8'hFF));
        chk("R1", "busy/done", 128'({busy_o, done_o}), 128'(0));
        chk("R1", "acc", acc_o, 128'(0));

        // R10: idle host loads
        for (int p = 0; p < 8; p++)
            for (int a = 0; a < 8; a++)
                tick(0, 1, p, a, 16'((p + 1) * (a * 7 + 3) - 20 + a * 16'h1234));
        readback("R10");

        run_prog(1);
        readback("R3");
        chk("R10", "busy write dropped", 128'(m_mem[0][15]), 128'(0));

        // R2: a second start reruns from address 0 with new data
        tick(0, 1, 3, 1, 16'h8000);
        tick(0, 1, 6, 0, 16'h7FFF);
        run_prog(0);
        readback("R3");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule